// File: doc/BRIEF.md
# Dual-Mode Serial ADC Host Controller

This block sits on the host side of a serial 10-bit, two-channel converter. It talks to the converter over three wires: an active-low select line, which also wakes the converter from shutdown; a serial clock; and a data line. The block runs one complete conversion for each accepted start request. The converter reads the serial clock level at the moment select falls, and that level tells it which clock mode to use. The host sets this level before it lowers select.

In external mode the host's serial clock both times the conversion and shifts the result out. In internal mode the converter uses its own oscillator. The host gives one falling edge to start the conversion, then watches the data line until it rises to mark the end of conversion, then clocks the result out. A timeout guards the wait.

The captured 13-bit word holds a channel bit, the 10-bit code MSB first, and two sub-LSB bits. The block presents it as separate fields with a one-cycle strobe. It then returns the converter to shutdown and keeps select high for a guaranteed minimum time before the next start.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is asserted and in the cycle after it, the outputs are `adc_cs_n`=1, `adc_sclk`=0, `res_valid`=0, `err_timeout`=0 and `busy`=1.
- R2: A start request seen while idle drives `adc_sclk` to the mode level (1 for internal, 0 for external) before `adc_cs_n` falls, and holds that level across the falling edge of `adc_cs_n`. The same level appears on `frame_internal`.
- R3: Internal mode is used when `cfg_internal`=1. It is also used when the serial clock rate SYS_CLK_HZ/(2*CLK_DIV) lies outside 100 kHz to 2.17 MHz, or when 13 serial periods exceed 140 us.
- R4: External frame: after `adc_cs_n` falls, the host gives 15 serial clock pulses, each CLK_DIV cycles low and then CLK_DIV cycles high. It samples the data line on rising edges 3 to 15, because the converter changes the data line on each falling edge from the one after rising edge 2 onward.
- R5: Internal frame: one falling edge of `adc_sclk` starts the conversion. The clock then stays low until the data line is seen high. After that the host gives 14 pulses and samples on rising edges 2 to 14.
- R6: The first sampled bit is `res_chan`. The next ten are `res_code[9]` down to `res_code[0]`. The last two are `res_sub[1]` then `res_sub[0]`.
- R7: `res_valid` is high for exactly one cycle. In that cycle `adc_cs_n` rises, `adc_sclk` is low, and the result fields hold the new word.
- R8: If the data line stays low for EOC_TIMEOUT cycles while the host waits in internal mode, `err_timeout` pulses for one cycle as `adc_cs_n` rises, and no result is strobed.
- R9: Between frames `adc_cs_n` stays high for at least CS_HIGH_MIN cycles. With start held high continuously, it stays high for exactly CS_HIGH_MIN+CLK_DIV+1 cycles. A start request made while a frame is in progress is ignored.
- R10: `busy` is high from the accepted start until the minimum high time ends, and is low only when the block is idle with `adc_cs_n` high and `adc_sclk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion, sampled only while idle |
| cfg_internal | input | 1 | Ask for internal conversion clock mode |
| adc_dout | input | 1 | Converter data line |
| adc_cs_n | output | 1 | Converter select / shutdown, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame or minimum high time in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 1 | Channel bit of the result |
| res_code | output | 10 | Conversion code |
| res_sub | output | 2 | Sub-LSB bits |
| err_timeout | output | 1 | One-cycle end-of-conversion timeout strobe |
| frame_internal | output | 1 | Mode used for the current or last frame (1 = internal) |

## Verification
Two things can fall in the same cycle: the end of the minimum high time and a pending start request. When both occur, the next frame must begin straight away and the high-time rule must still hold. The bench provokes this by holding `start` high across the end of a frame. It counts the exact number of cycles `adc_cs_n` stays high and requires two complete, correct results. A second case joins a forced mode choice with a frame start: an instance whose clock divider gives a rate outside the external window is asked for external mode. The bench judges it by the clock level the converter model sees at the select edge and by the data the model returns.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int FRAME_BITS    = 13;
  localparam int CODE_BITS     = 10;
  localparam int SUB_BITS      = 2;
  localparam int PCNT_W        = 5;
  localparam int EXT_PULSES    = 15;
  localparam int EXT_FIRST_CAP = 3;
  localparam int INT_PULSES    = 14;
  localparam int INT_FIRST_CAP = 2;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_IDLE,
    ST_SETUP,
    ST_CSLOW,
    ST_POLL,
    ST_SHIFT
  } host_st_t;
endpackage

// File: rtl/adc_rate_window.sv
module adc_rate_window #(
  parameter int SYS_CLK_HZ    = 100_000_000,
  parameter int CLK_DIV       = 50,
  parameter int EXT_MIN_HZ    = 100_000,
  parameter int EXT_MAX_HZ    = 2_170_000,
  parameter int HOLD_LIMIT_US = 140
) (
  output logic ext_ok
);
  import adc_host_pkg::*;

  localparam longint SCLK_HZ    = longint'(SYS_CLK_HZ) / (longint'(2) * longint'(CLK_DIV));
  localparam longint CONV_CLKS  = longint'(FRAME_BITS) * longint'(2) * longint'(CLK_DIV);
  localparam longint LIMIT_CLKS = (longint'(SYS_CLK_HZ) * longint'(HOLD_LIMIT_US)) / longint'(1_000_000);
  localparam bit     RATE_OK    = (SCLK_HZ >= longint'(EXT_MIN_HZ)) && (SCLK_HZ <= longint'(EXT_MAX_HZ));
  localparam bit     DROOP_OK   = (CONV_CLKS <= LIMIT_CLKS);

  assign ext_ok = RATE_OK && DROOP_OK;
endmodule

// File: rtl/adc_sclk_pulser.sv
module adc_sclk_pulser #(
  parameter int CLK_DIV = 50
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             go,
  input  logic [adc_host_pkg::PCNT_W-1:0]  n_pulses,
  input  logic [adc_host_pkg::PCNT_W-1:0]  first_cap,
  input  logic                             lvl_set,
  input  logic                             lvl_val,
  output logic                             sclk,
  output logic                             cap,
  output logic                             done
);
  import adc_host_pkg::*;

  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic              running;
  logic              high_ph;
  logic [DIV_W-1:0]  div_cnt;
  logic [PCNT_W-1:0] idx;
  logic [PCNT_W-1:0] n_q;
  logic [PCNT_W-1:0] fc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      high_ph <= 1'b0;
      div_cnt <= '0;
      idx     <= '0;
      n_q     <= '0;
      fc_q    <= '0;
      sclk    <= 1'b0;
      cap     <= 1'b0;
      done    <= 1'b0;
    end else begin
      cap  <= 1'b0;
      done <= 1'b0;
      if (go) begin
        running <= 1'b1;
        high_ph <= 1'b0;
        sclk    <= 1'b0;
        div_cnt <= '0;
        idx     <= PCNT_W'(1);
        n_q     <= n_pulses;
        fc_q    <= first_cap;
      end else if (running) begin
        if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
          div_cnt <= '0;
          if (!high_ph) begin
            high_ph <= 1'b1;
            sclk    <= 1'b1;
            cap     <= (idx >= fc_q);
          end else if (idx == n_q) begin
            running <= 1'b0;
            high_ph <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx     <= idx + PCNT_W'(1);
            high_ph <= 1'b0;
            sclk    <= 1'b0;
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end else if (lvl_set) begin
        sclk <= lvl_val;
      end
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 din_raw,
  input  logic                                 cap,
  output logic                                 din_s,
  output logic [adc_host_pkg::FRAME_BITS-1:0]  word
);
  import adc_host_pkg::*;

  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta  <= 1'b0;
      din_s <= 1'b0;
      word  <= '0;
    end else begin
      meta  <= din_raw;
      din_s <= meta;
      if (cap) begin
        word <= {word[FRAME_BITS-2:0], din_s};
      end
    end
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host #(
  parameter int SYS_CLK_HZ  = 100_000_000,
  parameter int CLK_DIV     = 50,
  parameter int EOC_TIMEOUT = 2000,
  parameter int CS_HIGH_MIN = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       cfg_internal,
  input  logic       adc_dout,
  output logic       adc_cs_n,
  output logic       adc_sclk,
  output logic       busy,
  output logic       res_valid,
  output logic       res_chan,
  output logic [9:0] res_code,
  output logic [1:0] res_sub,
  output logic       err_timeout,
  output logic       frame_internal
);
  import adc_host_pkg::*;

  localparam int MAX_A  = (EOC_TIMEOUT > CS_HIGH_MIN) ? EOC_TIMEOUT : CS_HIGH_MIN;
  localparam int MAX_B  = (MAX_A > CLK_DIV) ? MAX_A : CLK_DIV;
  localparam int CNT_W  = $clog2(MAX_B + 1);

  host_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic              ext_ok;
  logic              go;
  logic [PCNT_W-1:0] npul;
  logic [PCNT_W-1:0] fcap;
  logic              lvl_set;
  logic              lvl_val;
  logic              cap;
  logic              done;
  logic              din_s;
  logic [FRAME_BITS-1:0] word;
  logic              want_int;

  adc_rate_window #(
    .SYS_CLK_HZ (SYS_CLK_HZ),
    .CLK_DIV    (CLK_DIV)
  ) u_rate (
    .ext_ok (ext_ok)
  );

  adc_sclk_pulser #(
    .CLK_DIV (CLK_DIV)
  ) u_pulser (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .n_pulses  (npul),
    .first_cap (fcap),
    .lvl_set   (lvl_set),
    .lvl_val   (lvl_val),
    .sclk      (adc_sclk),
    .cap       (cap),
    .done      (done)
  );

  adc_frame_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .din_raw (adc_dout),
    .cap     (cap),
    .din_s   (din_s),
    .word    (word)
  );

  assign want_int = cfg_internal | ~ext_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_HOLD;
      cnt            <= '0;
      adc_cs_n       <= 1'b1;
      busy           <= 1'b1;
      res_valid      <= 1'b0;
      err_timeout    <= 1'b0;
      frame_internal <= 1'b0;
      go             <= 1'b0;
      npul           <= '0;
      fcap           <= '0;
      lvl_set        <= 1'b0;
      lvl_val        <= 1'b0;
      res_chan       <= 1'b0;
      res_code       <= '0;
      res_sub        <= '0;
    end else begin
      res_valid   <= 1'b0;
      err_timeout <= 1'b0;
      go          <= 1'b0;
      lvl_set     <= 1'b0;
      case (st)
        ST_HOLD: begin
          if (cnt == CNT_W'(CS_HIGH_MIN - 1)) begin
            cnt  <= '0;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_IDLE: begin
          if (start) begin
            frame_internal <= want_int;
            lvl_set        <= 1'b1;
            lvl_val        <= want_int;
            busy           <= 1'b1;
            cnt            <= '0;
            st             <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == CNT_W'(CLK_DIV - 1)) begin
            adc_cs_n <= 1'b0;
            cnt      <= '0;
            st       <= ST_CSLOW;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_CSLOW: begin
          if (cnt == CNT_W'(CLK_DIV - 1)) begin
            cnt <= '0;
            if (frame_internal) begin
              lvl_set <= 1'b1;
              lvl_val <= 1'b0;
              st      <= ST_POLL;
            end else begin
              go   <= 1'b1;
              npul <= PCNT_W'(EXT_PULSES);
              fcap <= PCNT_W'(EXT_FIRST_CAP);
              st   <= ST_SHIFT;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_POLL: begin
          if (din_s) begin
            go   <= 1'b1;
            npul <= PCNT_W'(INT_PULSES);
            fcap <= PCNT_W'(INT_FIRST_CAP);
            cnt  <= '0;
            st   <= ST_SHIFT;
          end else if (cnt == CNT_W'(EOC_TIMEOUT - 1)) begin
            adc_cs_n    <= 1'b1;
            err_timeout <= 1'b1;
            cnt         <= '0;
            st          <= ST_HOLD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (done) begin
            adc_cs_n  <= 1'b1;
            res_valid <= 1'b1;
            res_chan  <= word[FRAME_BITS-1];
            res_code  <= word[FRAME_BITS-2 -: CODE_BITS];
            res_sub   <= word[SUB_BITS-1:0];
            cnt       <= '0;
            st        <= ST_HOLD;
          end
        end
        default: begin
          cnt <= '0;
          st  <= ST_HOLD;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
  parameter int CS_HIGH_MIN = 20
) (
  input logic clk,
  input logic rst,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic busy,
  input logic res_valid,
  input logic err_timeout,
  input logic frame_internal
);
  localparam int HW = $clog2(CS_HIGH_MIN + 1) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
    end else if (!adc_cs_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt < HW'(CS_HIGH_MIN)) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  assert_mode_level_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (adc_sclk == frame_internal) && $stable(adc_sclk));

  assert_strobe_end_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(adc_cs_n) && !adc_sclk);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> $rose(adc_cs_n) && !res_valid);

  assert_min_high_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> (hi_cnt >= HW'(CS_HIGH_MIN)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> adc_cs_n && !adc_sclk);
endmodule

bind adc_serial_host adc_serial_host_chk #(
  .CS_HIGH_MIN (CS_HIGH_MIN)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .adc_cs_n       (adc_cs_n),
  .adc_sclk       (adc_sclk),
  .busy           (busy),
  .res_valid      (res_valid),
  .err_timeout    (err_timeout),
  .frame_internal (frame_internal)
);

// File: tb/sim_adc_serial_host.sv
module adc_conv_model #(
  parameter int CONV_CYC = 300
) (
  input  logic       clk,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       no_eoc,
  input  logic       chan,
  input  logic [9:0] code,
  input  logic [1:0] sub,
  output logic       dout,
  output logic       mode_seen,
  output int         rise_cnt,
  output int         cs_falls
);
  logic        cs_p = 1'b1;
  logic        sclk_p = 1'b0;
  logic [12:0] fr = '0;
  int          phase = 0;
  int          conv_left = 0;
  int          eoc_rise = 0;

  initial begin
    dout = 1'b0;
    mode_seen = 1'b0;
    rise_cnt = 0;
    cs_falls = 0;
  end

  always @(negedge clk) begin
    if (cs_p && !cs_n) begin
      mode_seen = sclk;
      rise_cnt  = 0;
      eoc_rise  = 0;
      phase     = 0;
      cs_falls  = cs_falls + 1;
      dout      = 1'b0;
      fr        = {chan, code, sub};
    end else if (!cs_n) begin
      if (!sclk_p && sclk) begin
        rise_cnt = rise_cnt + 1;
        if (phase == 2) eoc_rise = eoc_rise + 1;
      end
      if (sclk_p && !sclk) begin
        if (!mode_seen) begin
          if (rise_cnt >= 2)
            dout = (rise_cnt - 2 < 13) ? fr[12 - (rise_cnt - 2)] : 1'b0;
        end else if (phase == 0) begin
          phase     = 1;
          conv_left = CONV_CYC;
        end else if (phase == 2 && eoc_rise >= 1) begin
          dout = (eoc_rise - 1 < 13) ? fr[12 - (eoc_rise - 1)] : 1'b0;
        end
      end
      if (phase == 1) begin
        if (conv_left > 0) conv_left = conv_left - 1;
        else if (!no_eoc) begin
          phase = 2;
          dout  = 1'b1;
        end
      end
    end else begin
      dout = 1'b0;
    end
    cs_p   = cs_n;
    sclk_p = sclk;
  end
endmodule

module sim_adc_serial_host;
  localparam int CLK_PERIOD  = 10;
  localparam int DIV0        = 50;
  localparam int DIV1        = 12;
  localparam int CSH         = 20;
  localparam int TMO         = 2000;
  localparam int WATCH_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start0 = 1'b0, start1 = 1'b0;
  logic cfg_int = 1'b0;
  logic no_eoc = 1'b0;
  logic chan = 1'b0;
  logic [9:0] code = '0;
  logic [1:0] sub = '0;

  logic dout0, cs0, sclk0, busy0, val0, ch0, err0, fi0;
  logic [9:0] code0;
  logic [1:0] sub0;
  logic dout1, cs1, sclk1, busy1, val1, ch1, err1, fi1;
  logic [9:0] code1;
  logic [1:0] sub1;
  logic ms0, ms1;
  int   rc0, rc1, cf0, cf1;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [12:0] q0[$];
  logic [12:0] q1[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_serial_host #(.CLK_DIV(DIV0), .EOC_TIMEOUT(TMO), .CS_HIGH_MIN(CSH)) u0 (
    .clk(clk), .rst(rst), .start(start0), .cfg_internal(cfg_int), .adc_dout(dout0),
    .adc_cs_n(cs0), .adc_sclk(sclk0), .busy(busy0), .res_valid(val0), .res_chan(ch0),
    .res_code(code0), .res_sub(sub0), .err_timeout(err0), .frame_internal(fi0));

  adc_serial_host #(.CLK_DIV(DIV1), .EOC_TIMEOUT(TMO), .CS_HIGH_MIN(CSH)) u1 (
    .clk(clk), .rst(rst), .start(start1), .cfg_internal(cfg_int), .adc_dout(dout1),
    .adc_cs_n(cs1), .adc_sclk(sclk1), .busy(busy1), .res_valid(val1), .res_chan(ch1),
    .res_code(code1), .res_sub(sub1), .err_timeout(err1), .frame_internal(fi1));

  adc_conv_model #(.CONV_CYC(300)) m0 (
    .clk(clk), .cs_n(cs0), .sclk(sclk0), .no_eoc(no_eoc), .chan(chan), .code(code),
    .sub(sub), .dout(dout0), .mode_seen(ms0), .rise_cnt(rc0), .cs_falls(cf0));

  adc_conv_model #(.CONV_CYC(300)) m1 (
    .clk(clk), .cs_n(cs1), .sclk(sclk1), .no_eoc(no_eoc), .chan(chan), .code(code),
    .sub(sub), .dout(dout1), .mode_seen(ms1), .rise_cnt(rc1), .cs_falls(cf1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock reference comparison of result strobes (R6, R7)
  logic pv0 = 1'b0, pv1 = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (val0) begin
        if (q0.size() == 0) chk(1'b0, "R7 unexpected strobe u0", 1, 0);
        else begin
          logic [12:0] e;
          e = q0.pop_front();
          chk({ch0, code0, sub0} == e, "R6 result word u0", int'({ch0, code0, sub0}), int'(e));
        end
        chk(!pv0, "R7 single-cycle strobe u0", int'(pv0), 0);
      end
      if (val1) begin
        if (q1.size() == 0) chk(1'b0, "R7 unexpected strobe u1", 1, 0);
        else begin
          logic [12:0] e;
          e = q1.pop_front();
          chk({ch1, code1, sub1} == e, "R6 result word u1", int'({ch1, code1, sub1}), int'(e));
        end
      end
      pv0 = val0;
      pv1 = val1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCH_LIMIT) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCH_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic set_data(input logic c, input logic [9:0] d, input logic [1:0] s);
    @(negedge clk);
    chan = c;
    code = d;
    sub  = s;
  endtask

  task automatic wait_end0(output bit saw_val, output bit saw_err, output logic cs_at);
    saw_val = 0;
    saw_err = 0;
    cs_at   = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (val0 || err0) begin
        saw_val = val0;
        saw_err = err0;
        cs_at   = cs0;
        break;
      end
    end
  endtask

  task automatic frame0(input bit intm, input logic c, input logic [9:0] d, input logic [1:0] s,
                        input int exp_rises);
    bit sv, se;
    logic csa;
    set_data(c, d, s);
    cfg_int = intm;
    q0.push_back({c, d, s});
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    wait_end0(sv, se, csa);
    chk(sv, "R7 result strobe seen", int'(sv), 1);
    chk(ms0 == intm, "R2 clock level at select fall", int'(ms0), int'(intm));
    chk(fi0 == intm, "R3 mode used", int'(fi0), int'(intm));
    chk(rc0 == exp_rises, intm ? "R5 internal pulse count" : "R4 external pulse count",
        rc0, exp_rises);
    @(negedge clk);
    chk(busy0 == 1'b1, "R10 busy during hold", int'(busy0), 1);
    repeat (CSH + 2) @(negedge clk);
    chk(busy0 == 1'b0, "R10 idle after hold", int'(busy0), 0);
  endtask

  initial begin
    bit sv, se;
    logic csa;
    int hi;
    int falls_before;

    repeat (3) @(negedge clk);
    chk(cs0 == 1'b1, "R1 reset select", int'(cs0), 1);
    chk(sclk0 == 1'b0, "R1 reset clock", int'(sclk0), 0);
    chk(val0 == 1'b0 && err0 == 1'b0, "R1 reset strobes", int'({val0, err0}), 0);
    chk(busy0 == 1'b1, "R1 reset busy", int'(busy0), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(cs0 == 1'b1 && busy0 == 1'b1, "R1 first cycle after reset", int'({cs0, busy0}), 3);
    repeat (CSH + 3) @(negedge clk);
    chk(busy0 == 1'b0, "R10 idle after reset hold", int'(busy0), 0);

    // external frames, several patterns (R4, R6)
    frame0(1'b0, 1'b1, 10'h3FF, 2'b11, 15);
    frame0(1'b0, 1'b0, 10'h000, 2'b00, 15);
    frame0(1'b0, 1'b1, 10'h2A5, 2'b10, 15);
    // internal frames (R5)
    frame0(1'b1, 1'b0, 10'h15A, 2'b01, 14);
    frame0(1'b1, 1'b1, 10'h201, 2'b10, 14);

    // timeout in internal mode (R8)
    no_eoc  = 1'b1;
    cfg_int = 1'b1;
    start0  = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    wait_end0(sv, se, csa);
    chk(se, "R8 timeout strobe", int'(se), 1);
    chk(!sv, "R8 no result on timeout", int'(sv), 0);
    chk(csa == 1'b1, "R8 select released", int'(csa), 1);
    no_eoc = 1'b0;
    repeat (CSH + 3) @(negedge clk);

    // start while busy is ignored (R9)
    falls_before = cf0;
    set_data(1'b0, 10'h0F0, 2'b01);
    cfg_int = 1'b0;
    q0.push_back({1'b0, 10'h0F0, 2'b01});
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    repeat (300) @(negedge clk);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    wait_end0(sv, se, csa);
    chk(sv, "R9 frame completes", int'(sv), 1);
    repeat (400) @(negedge clk);
    chk(cf0 - falls_before == 1, "R9 mid-frame start ignored", cf0 - falls_before, 1);

    // start held across the end of the hold time (R9)
    set_data(1'b1, 10'h3C3, 2'b11);
    cfg_int = 1'b0;
    q0.push_back({1'b1, 10'h3C3, 2'b11});
    q0.push_back({1'b1, 10'h3C3, 2'b11});
    start0 = 1'b1;
    wait_end0(sv, se, csa);
    hi = 0;
    while (cs0 && hi < 1000) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == CSH + DIV0 + 1, "R9 back-to-back high time", hi, CSH + DIV0 + 1);
    start0 = 1'b0;
    wait_end0(sv, se, csa);
    chk(sv, "R9 second back-to-back frame", int'(sv), 1);
    repeat (CSH + 3) @(negedge clk);
    chk(q0.size() == 0, "R6 all results returned", q0.size(), 0);

    // forced internal mode on out-of-window rate (R3)
    set_data(1'b0, 10'h1E7, 2'b10);
    cfg_int = 1'b0;
    q1.push_back({1'b0, 10'h1E7, 2'b10});
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (val1 || err1) break;
    end
    chk(ms1 == 1'b1, "R3 forced internal clock level", int'(ms1), 1);
    chk(fi1 == 1'b1, "R3 forced internal mode", int'(fi1), 1);
    chk(rc1 == 14, "R3 forced internal pulse count", rc1, 14);
    repeat (CSH + 3) @(negedge clk);
    chk(q1.size() == 0, "R3 forced internal result", q1.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule